// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller with Extended Sources

This block gathers interrupt requests for a small cluster of processors (two to four). Fifteen ordinary sources, numbered 1 to 15, carry their own priority: the larger the number, the more urgent the source. Sixteen further sources, numbered 16 to 31, have no level of their own. Instead they are presented to the processors through one ordinary line that software selects as the carrier.

Pending state is held once and shared by all processors. Each processor has its own enable mask, and it sees on a 4-bit level output the most urgent source that its mask allows. The processor answers with an acknowledge strobe and the level it took. The controller then retires that source. When the acknowledged level is the carrier line, the controller retires the most urgent extended source enabled for that processor instead, and records that source's number in the processor's identity register.

Software reaches the block through a simple word-addressed register bus. A single write-one strobe sets pending bits, and another clears them. A read-only status word reports the processor count.

Top module: `irqc_mp`

## Requirements
- R1: After reset the pending word, every processor mask, every identity register and the carrier selection read 0, and every level output is 0.
- R2: A rising edge on input line n (1 to 31) sets pending bit n in the next cycle. A line that is held high sets the bit only once: after the bit is cleared it stays clear until the line falls and rises again.
- R3: A write to offset 0x08 clears every pending bit whose written bit is 1. Written 0 bits leave their pending bits unchanged.
- R4: A write to offset 0x04 sets every pending bit n (1 to 31) whose written bit is 1.
- R5: Offset 0x00 returns the pending word with bit n for source n. Bit 0 always reads 0, and writes to this offset have no effect.
- R6: The mask of processor c is at offset 0x40+4c, where bit n = 1 enables source n. The level output of processor c is the highest number among sources 1 to 15 that are both pending and enabled for c, or 0 if there is none.
- R7: Bits 3:0 at offset 0x0C select the carrier line for extended sources. The value 0 turns the extended path off, and extended sources then never raise any level output.
- R8: While the carrier k is nonzero and enabled for processor c, and any extended source is both pending and enabled for c, processor c sees line k as pending.
- R9: An acknowledge from processor c with a level L that is not the carrier clears pending bit L in the next cycle.
- R10: An acknowledge from processor c with a level equal to a nonzero carrier clears the highest extended source that is pending and enabled for c, and also clears the carrier's own pending bit. The number of that extended source (16 to 31, so bit 4 is 1) is stored in c's identity register at offset 0x80+4c. If no such source exists, the register is set to 0.
- R11: Offset 0x10 reads with bits 31:28 equal to the processor count minus one, bit 27 equal to 0 (no broadcast capability), and all other bits 0.
- R12: When a clear (by bus write or by acknowledge) and a new set (by line edge or by force write) hit the same pending bit in the same cycle, the bit ends up set.
- R13: Read data appears on the read-data output in the cycle after the read request, and it is 0 in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | Interrupt request lines; bit n is source n, bit 0 unused |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| cpu_level | output | 4*NCPU | Interrupt level per processor, 4 bits each |
| cpu_ack | input | NCPU | Acknowledge strobe per processor |
| cpu_ack_lvl | input | 4*NCPU | Level being acknowledged per processor, 4 bits each |

## Verification
The pending word can be cleared and set for the same source in one cycle. The bench provokes this collision in two ways. First, it raises an input line in the same cycle as a clear write for that bit. Second, it lets an acknowledge coincide with new stimulus. It judges the result through the pending read and the level output, both of which must still show the source. It also has two processors acknowledge the carrier line in turn with different masks. Each must retire a different extended source and record its own identity.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // register byte offsets
    localparam logic [7:0] OFF_PEND  = 8'h00;
    localparam logic [7:0] OFF_FORCE = 8'h04;
    localparam logic [7:0] OFF_CLEAR = 8'h08;
    localparam logic [7:0] OFF_CARRY = 8'h0C;
    localparam logic [7:0] OFF_STAT  = 8'h10;
    localparam logic [7:0] OFF_MASK  = 8'h40;
    localparam logic [7:0] OFF_IDENT = 8'h80;

    localparam int NSRC = 32;

    // index of the highest set bit; 0 when none is set
    function automatic logic [3:0] top_bit16(input logic [15:0] v);
        logic [3:0] r;
        r = '0;
        for (int i = 0; i < 16; i++) begin
            if (v[i]) r = 4'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lines,
    output logic [W-1:0] rise
);
    logic [W-1:0] lines_d, lines_q;

    always_comb begin
        lines_d = lines;
        rise    = lines & ~lines_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lines_q <= '0;
        else        lines_q <= lines_d;
    end
endmodule

// File: rtl/irqc_cpu_sel.sv
module irqc_cpu_sel
    import irqc_pkg::*;
(
    input  logic [31:0] pend,
    input  logic [31:0] mask,
    input  logic [3:0]  carrier,
    output logic [3:0]  level,
    output logic        ext_hit,
    output logic [4:0]  ext_idx
);
    logic [15:0] ext_v;
    logic [15:0] low_v;

    always_comb begin
        ext_v   = pend[31:16] & mask[31:16];
        ext_hit = |ext_v;
        ext_idx = {1'b1, top_bit16(ext_v)};
        low_v   = pend[15:0];
        if (carrier != 4'd0 && ext_hit) low_v[carrier] = 1'b1;
        low_v   = low_v & mask[15:0];
        low_v[0] = 1'b0;
        level   = top_bit16(low_v);
    end
endmodule

// File: rtl/irqc_mp.sv
module irqc_mp
    import irqc_pkg::*;
#(
    parameter int NCPU = 2,
    parameter int AW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       irq_lines,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCPU*4-1:0] cpu_level,
    input  logic [NCPU-1:0]   cpu_ack,
    input  logic [NCPU*4-1:0] cpu_ack_lvl
);
    localparam logic [3:0] CPU_FIELD = 4'(NCPU - 1);

    typedef struct packed {
        logic [31:0]            pend;
        logic [3:0]             carrier;
        logic [NCPU-1:0][31:0]  mask;
        logic [NCPU-1:0][4:0]   ident;
        logic [31:0]            rdata;
    } st_t;

    st_t st_d, st_q;

    logic [31:0]     rise;
    logic [31:0]     set_vec;
    logic [31:0]     clr_vec;
    logic [3:0]      lvl   [NCPU];
    logic            ehit  [NCPU];
    logic [4:0]      eidx  [NCPU];
    logic [3:0]      ack_l [NCPU];

    logic wr_force, wr_clear, rd_req;
    assign wr_force = bus_sel && bus_we && bus_addr == AW'(OFF_FORCE);
    assign wr_clear = bus_sel && bus_we && bus_addr == AW'(OFF_CLEAR);
    assign rd_req   = bus_sel && !bus_we;

    irqc_edge #(.W(NSRC)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lines (irq_lines),
        .rise  (rise)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        irqc_cpu_sel u_sel (
            .pend    (st_q.pend),
            .mask    (st_q.mask[c]),
            .carrier (st_q.carrier),
            .level   (lvl[c]),
            .ext_hit (ehit[c]),
            .ext_idx (eidx[c])
        );
        assign cpu_level[c*4 +: 4] = lvl[c];
        assign ack_l[c]            = cpu_ack_lvl[c*4 +: 4];
    end

    always_comb begin
        st_d    = st_q;
        set_vec = rise | (wr_force ? bus_wdata : 32'd0);
        set_vec[0] = 1'b0;
        clr_vec = wr_clear ? bus_wdata : 32'd0;

        for (int c = 0; c < NCPU; c++) begin
            if (cpu_ack[c]) begin
                clr_vec = clr_vec | (32'd1 << ack_l[c]);
                if (st_q.carrier != 4'd0 && ack_l[c] == st_q.carrier) begin
                    if (ehit[c]) begin
                        clr_vec        = clr_vec | (32'd1 << eidx[c]);
                        st_d.ident[c]  = eidx[c];
                    end else begin
                        st_d.ident[c]  = 5'd0;
                    end
                end
            end
        end

        // set wins over clear in the same cycle
        st_d.pend    = (st_q.pend & ~clr_vec) | set_vec;
        st_d.pend[0] = 1'b0;

        if (bus_sel && bus_we) begin
            if (bus_addr == AW'(OFF_CARRY)) st_d.carrier = bus_wdata[3:0];
            for (int c = 0; c < NCPU; c++) begin
                if (bus_addr == AW'(OFF_MASK + 8'(4 * c))) st_d.mask[c] = bus_wdata;
            end
        end

        st_d.rdata = 32'd0;
        if (rd_req) begin
            if (bus_addr == AW'(OFF_PEND))  st_d.rdata = st_q.pend;
            if (bus_addr == AW'(OFF_CARRY)) st_d.rdata = {28'd0, st_q.carrier};
            if (bus_addr == AW'(OFF_STAT))  st_d.rdata = {CPU_FIELD, 1'b0, 27'd0};
            for (int c = 0; c < NCPU; c++) begin
                if (bus_addr == AW'(OFF_MASK + 8'(4 * c)))  st_d.rdata = st_q.mask[c];
                if (bus_addr == AW'(OFF_IDENT + 8'(4 * c))) st_d.rdata = {27'd0, st_q.ident[c]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    // ---------------- assertions ----------------
    assert_clear_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clear |=> ((st_q.pend & $past(bus_wdata) & ~$past(set_vec)) == 32'd0));

    assert_force_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_force && cpu_ack == '0) |=>
        ((st_q.pend & $past(bus_wdata) & 32'hFFFF_FFFE) == ($past(bus_wdata) & 32'hFFFF_FFFE)));

    assert_stat_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && bus_addr == AW'(OFF_STAT)) |=> (bus_rdata[31:27] == {CPU_FIELD, 1'b0}));

    assert_idle_rdata_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (bus_rdata == 32'd0));

    for (genvar c = 0; c < NCPU; c++) begin : g_chk
        assert_ident_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.ident[c] != 5'd0) |-> st_q.ident[c][4]);

        assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.mask[c] == 32'd0) |-> (cpu_level[c*4 +: 4] == 4'd0));

        assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_ack[c] && ack_l[c] != 4'd0 && ack_l[c] != st_q.carrier && !set_vec[ack_l[c]])
            |=> !st_q.pend[$past(ack_l[c])]);
    end
endmodule

// File: tb/tb_irqc_mp.sv
module tb_irqc_mp;
    localparam int NCPU = 2;
    localparam int AW   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       irq_lines = '0;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCPU*4-1:0] cpu_level;
    logic [NCPU-1:0]   cpu_ack = '0;
    logic [NCPU*4-1:0] cpu_ack_lvl = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irqc_mp #(.NCPU(NCPU), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_level(cpu_level), .cpu_ack(cpu_ack), .cpu_ack_lvl(cpu_ack_lvl)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ack(input int c, input logic [3:0] l);
        cpu_ack[c] = 1'b1; cpu_ack_lvl[c*4 +: 4] = l;
        @(negedge clk);
        cpu_ack = '0; cpu_ack_lvl = '0;
    endtask

    function automatic logic [31:0] lvl(input int c);
        return {28'd0, cpu_level[c*4 +: 4]};
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        rd(8'h00, d); chk("R1 pending", d, 32'd0);
        rd(8'h40, d); chk("R1 mask0", d, 32'd0);
        rd(8'h84, d); chk("R1 ident1", d, 32'd0);
        rd(8'h0C, d); chk("R1 carrier", d, 32'd0);
        chk("R1 levels", {24'd0, cpu_level}, 32'd0);
        @(negedge clk);
        chk("R13 idle rdata", bus_rdata, 32'd0);
    endtask

    task automatic t_status;
        logic [31:0] d;
        rd(8'h10, d); chk("R11 status word", d, 32'h1000_0000);
    endtask

    task automatic t_edge;
        logic [31:0] d;
        wr(8'h40, 32'h0000_FFFE);
        irq_lines[5] = 1'b1;
        @(negedge clk);
        chk("R2 edge level cpu0", lvl(0), 32'd5);
        chk("R6 cpu1 masked", lvl(1), 32'd0);
        wr(8'h08, 32'h0000_0000);
        rd(8'h00, d); chk("R3 zero write keeps", d, 32'h0000_0020);
        wr(8'h08, 32'h0000_0020);
        repeat (3) @(negedge clk);
        rd(8'h00, d); chk("R2 held line no retrigger", d, 32'd0);
        irq_lines[5] = 1'b0;
        @(negedge clk);
        irq_lines[5] = 1'b1;
        @(negedge clk);
        rd(8'h00, d); chk("R2 new edge", d, 32'h0000_0020);
        irq_lines[5] = 1'b0;
        wr(8'h08, 32'hFFFF_FFFF);
    endtask

    task automatic t_force;
        logic [31:0] d;
        wr(8'h04, 32'h0000_0108);
        rd(8'h00, d); chk("R4 force bits", d, 32'h0000_0108);
        chk("R6 highest level", lvl(0), 32'd8);
        wr(8'h40, 32'h0000_FEFE);
        chk("R6 mask lowers level", lvl(0), 32'd3);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'h0000_0001);
        rd(8'h00, d); chk("R5 write ignored bit0 zero", d, 32'h0000_0108);
        ack(0, 4'd3);
        rd(8'h00, d); chk("R9 ack clears", d, 32'h0000_0100);
        chk("R6 none unmasked", lvl(0), 32'd0);
        wr(8'h08, 32'hFFFF_FFFF);
    endtask

    task automatic t_ext;
        logic [31:0] d;
        wr(8'h0C, 32'd12);
        wr(8'h40, 32'hFFFF_FFFE);
        wr(8'h44, 32'h0010_1000);
        wr(8'h04, 32'h0210_0000);
        chk("R8 carrier cpu0", lvl(0), 32'd12);
        chk("R8 carrier cpu1", lvl(1), 32'd12);
        ack(0, 4'd12);
        rd(8'h00, d); chk("R10 highest ext retired", d, 32'h0010_0000);
        rd(8'h80, d); chk("R10 ident cpu0", d, 32'h0000_0019);
        chk("R8 carrier still held", lvl(0), 32'd12);
        ack(1, 4'd12);
        rd(8'h84, d); chk("R10 ident cpu1", d, 32'h0000_0014);
        rd(8'h00, d); chk("R10 all retired", d, 32'd0);
        chk("R8 carrier drops", lvl(0), 32'd0);
        wr(8'h0C, 32'd0);
        wr(8'h04, 32'h0010_0000);
        chk("R7 path off", lvl(0), 32'd0);
        wr(8'h08, 32'hFFFF_FFFF);
    endtask

    task automatic t_collide;
        logic [31:0] d;
        wr(8'h40, 32'h0000_FFFE);
        wr(8'h04, 32'h0000_0080);
        irq_lines[7] = 1'b1;
        wr(8'h08, 32'h0000_0080);
        rd(8'h00, d); chk("R12 set beats clear", d, 32'h0000_0080);
        chk("R12 level kept", lvl(0), 32'd7);
        cpu_ack[0] = 1'b1; cpu_ack_lvl[3:0] = 4'd9;
        wr(8'h04, 32'h0000_0200);
        cpu_ack = '0; cpu_ack_lvl = '0;
        rd(8'h00, d); chk("R12 force beats ack", d, 32'h0000_0280);
        irq_lines[7] = 1'b0;
        wr(8'h08, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status();
        t_edge();
        t_force();
        t_ext();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule